// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor Core

This block is a small multicycle processor built around one 8-bit accumulator. It has a single 8-bit scratch register and a zero flag. It reaches a 16-bit address space through one memory bus, and peripherals are placed at ordinary addresses in that space. Every instruction begins with a one-byte opcode. Instructions that name a memory location or a branch target are followed by two address bytes, low byte first.

The address always comes from an internal address register. Read data is taken combinationally from the addressed location in the same cycle. A write is committed at the rising edge that ends a cycle in which the write strobe is high. Internally the core sequences a fixed state chain through a program counter, an address register, a data register, a temporary byte register and an instruction register. None of these is visible to software.

Top module: `acc_cpu`

## Requirements
- R1: While rst_n is low and after it is released, PC, accumulator, scratch register and zero flag are all zero, mem_addr is 0000H and mem_we is low, so the first opcode is read from address 0000H.
- R2: Opcodes are taken from successive bytes starting at PC, with PC stepping by one per byte read. The byte values are: 00H no-op, 01H load accumulator, 02H store accumulator, 03H copy accumulator to scratch, 04H copy scratch to accumulator, 05H jump, 06H jump if zero flag set, 07H jump if zero flag clear, 08H add, 09H subtract, 0AH increment, 0BH clear, 0CH AND, 0DH OR, 0EH XOR, 0FH invert.
- R3: Opcodes 01H, 02H, 05H, 06H and 07H are three bytes long: the opcode, then the address low byte, then the address high byte. The operand address is the high byte concatenated with the low byte.
- R4: A load puts the byte at the operand address into the accumulator. A store drives mem_we high for exactly one cycle, with mem_addr equal to the operand address and mem_wdata equal to the accumulator.
- R5: Opcode 03H copies the accumulator into the scratch register, and 04H copies the scratch register into the accumulator.
- R6: Arithmetic and logic results are taken modulo 256 and written to the accumulator: add gives AC+R, subtract gives AC-R, increment gives AC+1, clear gives 0, AND/OR/XOR combine AC with R, and invert gives the bitwise complement of AC.
- R7: The zero flag is updated only by opcodes 08H to 0FH. It is set when the 8-bit result is zero and cleared otherwise. Loads, stores, copies and jumps leave it as it was.
- R8: 05H always branches to its operand address. 06H branches when the zero flag is set, and 07H branches when it is clear.
- R9: When a conditional branch is not taken, execution continues at the byte that follows the three-byte instruction.
- R10: Any opcode outside 00H to 0FH behaves as a one-byte no-op.
- R11: A one-byte instruction takes 3 cycles, a jump takes 6 cycles, and a load or store takes 7 cycles. For a store, the write cycle is the seventh cycle of the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Bus address, driven from the address register |
| mem_rdata | input | 8 | Byte read from mem_addr in the same cycle |
| mem_wdata | output | 8 | Byte to be written (accumulator contents) |
| mem_we | output | 1 | Write strobe, committed at the rising edge |

## Verification
The bench builds the core with its default 8-bit data width and a 16-bit address. Its memory model decodes only the low 12 address bits, so each address byte still reaches the core through its own high-byte path. A generated program runs all eight arithmetic and logic opcodes over every pair drawn from sixteen operand values spread evenly across the byte range. That sweep covers wrap-around in add and subtract, all-ones and all-zeros patterns, and equal operands. Each result and each zero-flag outcome is written back to memory, and the bench compares them with values it computes itself. A directed program covers the reset contents, both outcomes of each conditional branch, copies, an undefined opcode, and the exact cycle of each write strobe.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam logic [7:0] OPC_NOP  = 8'h00;
    localparam logic [7:0] OPC_LDA  = 8'h01;
    localparam logic [7:0] OPC_STA  = 8'h02;
    localparam logic [7:0] OPC_A2R  = 8'h03;
    localparam logic [7:0] OPC_R2A  = 8'h04;
    localparam logic [7:0] OPC_JMP  = 8'h05;
    localparam logic [7:0] OPC_JZ   = 8'h06;
    localparam logic [7:0] OPC_JNZ  = 8'h07;
    localparam logic [7:0] OPC_ADD  = 8'h08;
    localparam logic [7:0] OPC_SUB  = 8'h09;
    localparam logic [7:0] OPC_INC  = 8'h0A;
    localparam logic [7:0] OPC_CLR  = 8'h0B;
    localparam logic [7:0] OPC_AND  = 8'h0C;
    localparam logic [7:0] OPC_OR   = 8'h0D;
    localparam logic [7:0] OPC_XOR  = 8'h0E;
    localparam logic [7:0] OPC_NOT  = 8'h0F;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_INC, ALU_CLR,
        ALU_AND, ALU_OR,  ALU_XOR, ALU_NOT
    } alu_op_e;

    typedef enum logic [1:0] {
        JC_ALWAYS, JC_ZSET, JC_ZCLR
    } jcond_e;

    typedef enum logic [2:0] {
        S_FETCH_A, S_FETCH_D, S_DECODE, S_OPND_LO,
        S_OPND_HI, S_ADDR_JOIN, S_MEM_RD, S_MEM_WR
    } state_e;

    typedef struct packed {
        logic    has_addr;
        logic    is_load;
        logic    is_store;
        logic    is_jump;
        jcond_e  jcond;
        logic    is_alu;
        alu_op_e alu_op;
        logic    mv_a2r;
        logic    mv_r2a;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opcode_i,
    output ctrl_t             ctrl_o
);

    always_comb begin
        ctrl_o        = '0;
        ctrl_o.jcond  = JC_ALWAYS;
        ctrl_o.alu_op = ALU_ADD;
        case (opcode_i)
            DATA_W'(OPC_LDA): begin ctrl_o.has_addr = 1'b1; ctrl_o.is_load  = 1'b1; end
            DATA_W'(OPC_STA): begin ctrl_o.has_addr = 1'b1; ctrl_o.is_store = 1'b1; end
            DATA_W'(OPC_A2R): ctrl_o.mv_a2r = 1'b1;
            DATA_W'(OPC_R2A): ctrl_o.mv_r2a = 1'b1;
            DATA_W'(OPC_JMP): begin
                ctrl_o.has_addr = 1'b1; ctrl_o.is_jump = 1'b1; ctrl_o.jcond = JC_ALWAYS;
            end
            DATA_W'(OPC_JZ): begin
                ctrl_o.has_addr = 1'b1; ctrl_o.is_jump = 1'b1; ctrl_o.jcond = JC_ZSET;
            end
            DATA_W'(OPC_JNZ): begin
                ctrl_o.has_addr = 1'b1; ctrl_o.is_jump = 1'b1; ctrl_o.jcond = JC_ZCLR;
            end
            DATA_W'(OPC_ADD): begin ctrl_o.is_alu = 1'b1; ctrl_o.alu_op = ALU_ADD; end
            DATA_W'(OPC_SUB): begin ctrl_o.is_alu = 1'b1; ctrl_o.alu_op = ALU_SUB; end
            DATA_W'(OPC_INC): begin ctrl_o.is_alu = 1'b1; ctrl_o.alu_op = ALU_INC; end
            DATA_W'(OPC_CLR): begin ctrl_o.is_alu = 1'b1; ctrl_o.alu_op = ALU_CLR; end
            DATA_W'(OPC_AND): begin ctrl_o.is_alu = 1'b1; ctrl_o.alu_op = ALU_AND; end
            DATA_W'(OPC_OR):  begin ctrl_o.is_alu = 1'b1; ctrl_o.alu_op = ALU_OR;  end
            DATA_W'(OPC_XOR): begin ctrl_o.is_alu = 1'b1; ctrl_o.alu_op = ALU_XOR; end
            DATA_W'(OPC_NOT): begin ctrl_o.is_alu = 1'b1; ctrl_o.alu_op = ALU_NOT; end
            default: ;  // no-op, including every undefined byte (R10)
        endcase
    end

    // R10: at most one execution class is ever selected for a byte
    always_comb begin
        p_one_class_r10: assert ($onehot0({ctrl_o.is_load, ctrl_o.is_store, ctrl_o.is_jump,
                                           ctrl_o.is_alu, ctrl_o.mv_a2r, ctrl_o.mv_r2a}))
            else $error("decode selected more than one class");
    end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] reg_i,
    output logic [DATA_W-1:0] res_o,
    output logic              zero_o
);

    always_comb begin
        case (op_i)
            ALU_ADD: res_o = acc_i + reg_i;
            ALU_SUB: res_o = acc_i - reg_i;
            ALU_INC: res_o = acc_i + DATA_W'(1);
            ALU_CLR: res_o = '0;
            ALU_AND: res_o = acc_i & reg_i;
            ALU_OR:  res_o = acc_i | reg_i;
            ALU_XOR: res_o = acc_i ^ reg_i;
            default: res_o = ~acc_i;
        endcase
        zero_o = (res_o == '0);
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [2*DATA_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  mem_we
);

    localparam int ADDR_W = 2 * DATA_W;

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] tr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] r;
        logic              z;
    } regs_t;

    regs_t regs_d, regs_q;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] alu_res;
    logic              alu_zero;
    logic              jump_taken;
    logic              alu_exec;

    acc_cpu_decode #(.DATA_W(DATA_W)) u_decode (
        .opcode_i (regs_q.ir),
        .ctrl_o   (ctrl)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i   (ctrl.alu_op),
        .acc_i  (regs_q.ac),
        .reg_i  (regs_q.r),
        .res_o  (alu_res),
        .zero_o (alu_zero)
    );

    always_comb begin
        case (ctrl.jcond)
            JC_ZSET: jump_taken = regs_q.z;
            JC_ZCLR: jump_taken = ~regs_q.z;
            default: jump_taken = 1'b1;
        endcase
    end

    assign alu_exec = (regs_q.st == S_DECODE) && ctrl.is_alu;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            S_FETCH_A: begin
                regs_d.ar = regs_q.pc;
                regs_d.st = S_FETCH_D;
            end
            S_FETCH_D: begin
                regs_d.dr = mem_rdata;
                regs_d.ir = mem_rdata;
                regs_d.pc = regs_q.pc + ADDR_W'(1);
                regs_d.st = S_DECODE;
            end
            S_DECODE: begin
                if (ctrl.has_addr) begin
                    regs_d.ar = regs_q.pc;
                    regs_d.st = S_OPND_LO;
                end else begin
                    if (ctrl.is_alu) begin
                        regs_d.ac = alu_res;
                        regs_d.z  = alu_zero;
                    end
                    if (ctrl.mv_a2r) regs_d.r  = regs_q.ac;
                    if (ctrl.mv_r2a) regs_d.ac = regs_q.r;
                    regs_d.st = S_FETCH_A;
                end
            end
            S_OPND_LO: begin
                regs_d.tr = mem_rdata;
                regs_d.pc = regs_q.pc + ADDR_W'(1);
                regs_d.ar = regs_q.pc + ADDR_W'(1);
                regs_d.st = S_OPND_HI;
            end
            S_OPND_HI: begin
                regs_d.dr = mem_rdata;
                regs_d.pc = regs_q.pc + ADDR_W'(1);
                regs_d.st = S_ADDR_JOIN;
            end
            S_ADDR_JOIN: begin
                regs_d.ar = {regs_q.dr, regs_q.tr};
                if (ctrl.is_jump) begin
                    if (jump_taken) regs_d.pc = {regs_q.dr, regs_q.tr};
                    regs_d.st = S_FETCH_A;
                end else if (ctrl.is_load) begin
                    regs_d.st = S_MEM_RD;
                end else begin
                    regs_d.st = S_MEM_WR;
                end
            end
            S_MEM_RD: begin
                regs_d.dr = mem_rdata;
                regs_d.ac = mem_rdata;
                regs_d.st = S_FETCH_A;
            end
            default: begin
                regs_d.st = S_FETCH_A;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q    <= '0;
            regs_q.st <= S_FETCH_A;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_addr  = regs_q.ar;
    assign mem_wdata = regs_q.ac;
    assign mem_we    = (regs_q.st == S_MEM_WR);

    // R4: a store strobe never lasts more than one cycle
    p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4: the write goes to the address assembled from the operand bytes
    p_store_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == {regs_q.dr, regs_q.tr}));

    // R2: an opcode byte is read from the location PC points at
    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == S_FETCH_D) |-> (mem_addr == regs_q.pc));

    // R3: by the time the operand is assembled, PC has moved past both address bytes
    p_pc_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == S_ADDR_JOIN) |-> (regs_q.pc == $past(regs_q.pc, 3) + ADDR_W'(2)));

    // R7: the flag stays put unless an arithmetic/logic opcode just executed
    p_z_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!alu_exec) |-> $stable(regs_q.z));

    // R7: after an arithmetic/logic opcode the flag reflects the new accumulator
    p_z_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alu_exec) |-> (regs_q.z == (regs_q.ac == '0)));

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_DEPTH  = 4096;
    localparam int A_ADDR     = 16'h0800;
    localparam int B_ADDR     = 16'h0801;
    localparam int ONE_ADDR   = 16'h0802;
    localparam int RES_BASE   = 16'h0810;
    localparam int ZFL_BASE   = 16'h0820;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;

    logic [7:0]  img [MEM_DEPTH];
    logic [7:0]  mem [MEM_DEPTH];

    int checks = 0;
    int fails  = 0;
    int wp     = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_cpu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= img[i];
        end else if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_img(input logic [7:0] v);
        for (int i = 0; i < MEM_DEPTH; i++) img[i] = v;
        wp = 0;
    endtask

    task automatic emit1(input logic [7:0] b);
        img[wp] = b;
        wp++;
    endtask

    // three-byte form: opcode, address low, address high (R3)
    task automatic emit3(input logic [7:0] op, input int addr);
        emit1(op);
        emit1(addr[7:0]);
        emit1(addr[15:8]);
    endtask

    // hold reset, check the idle bus, release on a falling edge (R1)
    task automatic start_run;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset mem_addr", int'(mem_addr), 0);
        check("R1", "reset mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] op_code(input int k);
        case (k)
            0: return 8'h08; 1: return 8'h09; 2: return 8'h0A; 3: return 8'h0B;
            4: return 8'h0C; 5: return 8'h0D; 6: return 8'h0E; default: return 8'h0F;
        endcase
    endfunction

    function automatic logic [7:0] model(input int k, input logic [7:0] a, input logic [7:0] b);
        case (k)
            0: return a + b;
            1: return a - b;
            2: return a + 8'd1;
            3: return 8'd0;
            4: return a & b;
            5: return a | b;
            6: return a ^ b;
            default: return ~a;
        endcase
    endfunction

    // R6/R7/R9 sweep: every ALU opcode over a grid of operand pairs
    task automatic sweep_pair(input logic [7:0] a, input logic [7:0] b);
        clear_img(8'h00);
        img[A_ADDR] = a;
        img[B_ADDR] = b;
        img[ONE_ADDR] = 8'h01;
        for (int k = 0; k < 8; k++) begin
            emit3(8'h01, B_ADDR);          // AC <- b
            emit1(8'h03);                  // R <- AC
            emit3(8'h01, A_ADDR);          // AC <- a
            emit1(op_code(k));             // AC <- f(a, b), Z updated
            emit3(8'h02, RES_BASE + k);    // store result
            emit3(8'h01, ONE_ADDR);        // AC <- 1, Z must survive
            emit3(8'h07, wp + 6);          // skip marker when Z clear
            emit3(8'h02, ZFL_BASE + k);    // marker 01 when Z set
        end
        emit3(8'h05, wp);                  // park
        start_run();
        repeat (400) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            e = model(k, a, b);
            check("R6", $sformatf("op %0h a=%0h b=%0h result", op_code(k), a, b),
                  int'(mem[RES_BASE + k]), int'(e));
            check("R7", $sformatf("op %0h a=%0h b=%0h zero flag", op_code(k), a, b),
                  int'(mem[ZFL_BASE + k]), (e == 8'h00) ? 1 : 0);
        end
    endtask

    task automatic directed;
        int we_hits [$];
        clear_img(8'h00);
        for (int i = 16'h0830; i < 16'h0840; i++) img[i] = 8'hEE;
        img[A_ADDR] = 8'h55;
        img[ONE_ADDR] = 8'h01;
        emit3(8'h02, 16'h0835);            // R1: AC is zero after reset
        emit1(8'h04);                      // AC <- R (zero after reset)
        emit3(8'h02, 16'h0836);
        emit3(8'h06, 16'h0E00);            // R9: Z clear after reset, falls through
        emit1(8'h0B);                      // clear: Z set
        emit3(8'h06, 16'h0C34);            // R8: taken
        emit3(8'h02, 16'h0830);            // must be skipped
        emit3(8'h05, wp);
        wp = 16'h0C34;
        emit3(8'h01, ONE_ADDR);            // AC = 1
        emit1(8'h0A);                      // AC = 2, Z clear
        emit1(8'h3C);                      // R10: undefined byte
        emit3(8'h06, 16'h0E00);            // R9: not taken
        emit3(8'h02, 16'h0832);            // expect 02
        emit1(8'h03);                      // R5: R = 2
        emit3(8'h01, A_ADDR);              // AC = 55, Z untouched
        emit1(8'h04);                      // AC = 2
        emit3(8'h02, 16'h0833);            // expect 02
        emit3(8'h07, 16'h0C60);            // R8: taken, Z clear
        emit3(8'h02, 16'h0837);            // must be skipped
        wp = 16'h0C60;
        emit3(8'h02, 16'h0838);            // expect 02
        emit3(8'h05, wp);
        wp = 16'h0E00;
        emit3(8'h02, 16'h0834);            // must never run
        emit3(8'h05, wp);
        start_run();
        for (int c = 1; c <= 400; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (mem_we && c <= 20) we_hits.push_back(c);
        end
        // R11: stores at 7 cycles each, copy at 3: strobes after edges 6 and 16
        check("R11", "first store strobe count", we_hits.size(), 2);
        if (we_hits.size() >= 2) begin
            check("R11", "first store cycle", we_hits[0], 6);
            check("R11", "second store cycle", we_hits[1], 16);
        end
        check("R1", "accumulator cleared by reset", int'(mem[16'h0835]), 0);
        check("R1", "scratch cleared by reset", int'(mem[16'h0836]), 0);
        check("R8", "skipped store after taken JZ", int'(mem[16'h0830]), 8'hEE);
        check("R9", "untaken JZ target never reached", int'(mem[16'h0834]), 8'hEE);
        check("R10", "undefined opcode keeps AC", int'(mem[16'h0832]), 2);
        check("R5", "copy round trip through scratch", int'(mem[16'h0833]), 2);
        check("R8", "skipped store after taken JNZ", int'(mem[16'h0837]), 8'hEE);
        check("R3", "store at far target reached", int'(mem[16'h0838]), 2);
        check("R4", "load value unchanged in memory", int'(mem[A_ADDR]), 8'h55);
        check("R2", "opcode at 0000H unchanged", int'(mem[0]), 8'h02);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        clear_img(8'h00);
        directed();
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                sweep_pair(8'(i * 17), 8'(j * 17));
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule